// File: doc/BRIEF.md
# Sensor Register Target on a Two-Wire Serial Bus

This block lets a bus controller reach a small bank of sensor registers over a two-wire serial bus (I2C). The block samples the clock and data lines with its own system clock. It drives the data line only through a pull-low enable, and it answers one fixed 7-bit target address.

- A write transaction carries a register pointer byte and then a single data byte.
- A read uses a repeated START with the read flag set. It returns the register at the pointer, then the registers that follow it.

Bit 0 of the mode register selects the operating state:

- **Standby:** every register accepts writes.
- **Wake:** only the mode register accepts writes. Writes to other registers are acknowledged on the bus but discarded.

A set of sample registers takes fresh data from a sample strobe, but only while no bus transaction is in progress. A strobe that arrives between START and STOP is dropped. At least one STOP must therefore fall between samples for a new value to become visible.

Top module: `sensor_i2c_target`

## Requirements
- R1: The address byte 0x98 (7-bit address 0x4C, R/W flag in bit 0 equal to 0 for write) and the byte 0x99 (R/W flag 1, read) are acknowledged. Acknowledge means the target holds SDA low during the 9th clock.
- R2: An address byte with any other 7-bit address is not acknowledged. Later bytes up to the next START or STOP are also not acknowledged and change no register.
- R3: In a write transaction, the second byte sets the register pointer and the third byte is stored in the register it selects. Both bytes are acknowledged.
- R4: Only one data byte is taken per write transaction. A fourth byte is not acknowledged and is not stored in any register.
- R5: After reset all registers read 0x00, which puts the block in standby. In standby every implemented register is writable, including the sample registers at addresses 0 to 2.
- R6: While bit 0 of the mode register (address 0x07) is 1 (wake), writes to any other address are acknowledged but leave the register unchanged. Writes to the mode register still take effect, so writing 0x00 returns the block to standby.
- R7: After a repeated START with address byte 0x99, the target returns the register at the current pointer, MSB first. The pointer advances by one after each byte the controller acknowledges.
- R8: A sample strobe while the bus is idle loads sample input byte i (bits 8i+7..8i) into register i, for i = 0, 1, 2.
- R9: A sample strobe between a START and the following STOP changes no sample register.
- R10: The target only ever pulls SDA low. The pull-low enable is inactive during reset and whenever no transaction is in progress.
- R11: Addresses from 0x08 upward are not implemented. Writes to them are discarded and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (open-drain input) |
| sda_pull_o | output | 1 | High to pull the data line low |
| sample_stb_i | input | 1 | One-cycle pulse announcing a new sample |
| sample_data_i | input | 24 | New sample bytes, byte i for register i |

## Verification
A bit counter or state that is off by one moves the acknowledge to the wrong serial clock. The controller then sees a NAK on the same byte, within one byte time. A pointer that is wrong or fails to advance gives back the wrong register on the next read. A wrong wake decision either lets a forbidden write through or blocks a permitted one. That error shows up at the first read of the affected register after the write. A busy flag that fails to track START and STOP either lets a sample overwrite a register mid-transaction or keeps the bus driven after STOP. The first case is visible on the next read, the second on the line at once.

// File: rtl/sensor_i2c_pkg.sv
package sensor_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop,
  output logic busy
);
  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic              scl_prev_q, sda_prev_q;
  logic              busy_q, busy_n;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
      busy_q     <= 1'b0;
    end else begin
      scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
      busy_q     <= busy_n;
    end
  end

  assign scl_s     = scl_sh_q[STAGES-1];
  assign sda_s     = sda_sh_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign bus_start = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign bus_stop  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  assign busy      = busy_q;

  always_comb begin
    busy_n = busy_q;
    if (bus_start)     busy_n = 1'b1;
    else if (bus_stop) busy_n = 1'b0;
  end

  // R10
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> busy);
  // R10
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !busy);
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import sensor_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull
);
  tgt_state_t        state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sr_q, sr_n, tx_q, tx_n, ptr_q, ptr_n, wdat_q, wdat_n;
  logic              rw_q, rw_n, pull_q, pull_n, mack_q, mack_n, wen_q, wen_n;
  logic              byte_done;

  assign byte_done = scl_fall && (cnt_q == 4'd8);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sr_n    = sr_q;
    tx_n    = tx_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    pull_n  = pull_q;
    mack_n  = mack_q;
    wen_n   = 1'b0;
    wdat_n  = wdat_q;
    if (bus_stop) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      pull_n  = 1'b0;
    end else if (bus_start) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      pull_n  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sr_n  = {sr_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (sr_q[7:1] == TARGET_ADDR) begin
                rw_n    = sr_q[0];
                pull_n  = 1'b1;
                state_n = ST_ADDR_ACK;
              end else begin
                state_n = ST_IGNORE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_n   = sr_q;
              pull_n  = 1'b1;
              state_n = ST_PTR_ACK;
            end else begin
              wen_n   = 1'b1;
              wdat_n  = sr_q;
              pull_n  = 1'b1;
              state_n = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              tx_n    = rd_data;
              pull_n  = ~rd_data[7];
              state_n = ST_RDATA;
            end else begin
              pull_n  = 1'b0;
              state_n = ST_PTR;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall) begin
            cnt_n   = '0;
            pull_n  = 1'b0;
            state_n = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            pull_n  = 1'b0;
            state_n = ST_IGNORE;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (byte_done) begin
            pull_n  = 1'b0;
            state_n = ST_RACK;
          end else if (scl_fall) begin
            tx_n   = {tx_q[BYTE_W-2:0], 1'b0};
            pull_n = ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s) ptr_n = ptr_q + 8'd1;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_n    = rd_data;
              pull_n  = ~rd_data[7];
              cnt_n   = '0;
              state_n = ST_RDATA;
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
      mack_q  <= 1'b0;
      wen_q   <= 1'b0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      tx_q    <= tx_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
      pull_q  <= pull_n;
      mack_q  <= mack_n;
      wen_q   <= wen_n;
      wdat_q  <= wdat_n;
    end
  end

  assign ptr      = ptr_q;
  assign wr_en    = wen_q;
  assign wr_data  = wdat_q;
  assign sda_pull = pull_q;

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_pull);
  // R3
  write_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_pull);
  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/sensor_reg_bank.sv
module sensor_reg_bank
  import sensor_i2c_pkg::*;
#(
  parameter int                NUM_REGS    = 8,
  parameter int                NUM_SAMPLES = 3,
  parameter logic [BYTE_W-1:0] MODE_ADDR   = 8'h07,
  parameter logic              WAKE_VAL    = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          busy,
  input  logic                          sample_stb,
  input  logic [NUM_SAMPLES*BYTE_W-1:0] sample_data,
  input  logic                          wr_en,
  input  logic [BYTE_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [BYTE_W-1:0]             rd_addr,
  output logic [BYTE_W-1:0]             rd_data
);
  localparam int         IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0] REG_LIMIT = 9'(NUM_REGS);
  localparam int         MODE_IDX  = int'(MODE_ADDR);

  logic [NUM_REGS-1:0][BYTE_W-1:0] reg_q, reg_n;
  logic wake, wr_hit, rd_hit, wr_allowed, load_ok;

  assign wake       = (reg_q[MODE_IDX][0] == WAKE_VAL);
  assign wr_hit     = ({1'b0, wr_addr} < REG_LIMIT);
  assign rd_hit     = ({1'b0, rd_addr} < REG_LIMIT);
  assign wr_allowed = wr_en && wr_hit && (!wake || (wr_addr == MODE_ADDR));
  assign load_ok    = sample_stb && !busy;
  assign rd_data    = rd_hit ? reg_q[rd_addr[IDX_W-1:0]] : '0;

  always_comb begin
    reg_n = reg_q;
    if (load_ok) begin
      for (int i = 0; i < NUM_SAMPLES; i++) begin
        reg_n[i] = sample_data[i*BYTE_W +: BYTE_W];
      end
    end
    if (wr_allowed) reg_n[wr_addr[IDX_W-1:0]] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_n;
  end

  // R6
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wake && (wr_addr != MODE_ADDR) && !sample_stb) |=> $stable(reg_q));
  // R11
  unmapped_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit && !sample_stb) |=> $stable(reg_q));
  // R9
  busy_sample_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && busy && !wr_en) |=> $stable(reg_q));
  // R8
  idle_sample_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !busy) |=> (reg_q[0] == $past(sample_data[BYTE_W-1:0])));
endmodule

// File: rtl/sensor_i2c_target.sv
module sensor_i2c_target
  import sensor_i2c_pkg::*;
#(
  parameter logic [6:0]        TARGET_ADDR = 7'h4C,
  parameter int                NUM_REGS    = 8,
  parameter int                NUM_SAMPLES = 3,
  parameter logic [BYTE_W-1:0] MODE_ADDR   = 8'h07,
  parameter logic              WAKE_VAL    = 1'b1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  output logic                          sda_pull_o,
  input  logic                          sample_stb_i,
  input  logic [NUM_SAMPLES*BYTE_W-1:0] sample_data_i
);
  logic [1:0]        rst_sh_q;
  logic              rst_s_n;
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop, busy;
  logic              wr_en;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .busy(busy)
  );

  i2c_target_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .busy(busy), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  sensor_reg_bank #(
    .NUM_REGS(NUM_REGS), .NUM_SAMPLES(NUM_SAMPLES),
    .MODE_ADDR(MODE_ADDR), .WAKE_VAL(WAKE_VAL)
  ) u_bank (
    .clk(clk), .rst_n(rst_s_n), .busy(busy), .sample_stb(sample_stb_i),
    .sample_data(sample_data_i), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
  );

  // R10
  reset_release_chk: assert property (@(posedge clk)
    !rst_s_n |-> !sda_pull_o);
endmodule

// File: tb/sensor_i2c_target_tb.sv
module sensor_i2c_target_tb;
  localparam int Q = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sample_stb = 1'b0;
  logic [23:0] sample_data = '0;
  logic        sda_pull;
  wire         sda = ~(m_low | sda_pull);

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sensor_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_pull_o(sda_pull), .sample_stb_i(sample_stb),
    .sample_data_i(sample_data)
  );

  // {is_read, register, write data, expected read}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h03, 8'hA5, 8'h00},
    {1'b1, 8'h03, 8'h00, 8'hA5},
    {1'b0, 8'h01, 8'h5A, 8'h00},
    {1'b1, 8'h01, 8'h00, 8'h5A},
    {1'b0, 8'h07, 8'h01, 8'h00},
    {1'b0, 8'h03, 8'hFF, 8'h00},
    {1'b1, 8'h03, 8'h00, 8'hA5},
    {1'b0, 8'h01, 8'h77, 8'h00},
    {1'b1, 8'h01, 8'h00, 8'h5A},
    {1'b1, 8'h07, 8'h00, 8'h01},
    {1'b0, 8'h07, 8'h00, 8'h00},
    {1'b0, 8'h03, 8'h3C, 8'h00},
    {1'b1, 8'h03, 8'h00, 8'h3C},
    {1'b0, 8'h0A, 8'h99, 8'h00},
    {1'b1, 8'h0A, 8'h00, 8'h00}
  };
  localparam string VTAG [NV] = '{
    "R3", "R3", "R5", "R5", "R6", "R6", "R6", "R6", "R6", "R6",
    "R6", "R5", "R5", "R11", "R11"
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    end
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    acked = ~sda;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
      b[i] = sda;
      tick(Q); scl = 1'b0; tick(Q);
    end
    m_low = give_ack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    m_low = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] r, input logic [7:0] d, output bit all_ack);
    bit a0, a1, a2;
    bus_start(); send_byte(8'h98, a0); send_byte(r, a1); send_byte(d, a2); bus_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] r, output logic [7:0] d, output bit all_ack);
    bit a0, a1, a2;
    bus_start(); send_byte(8'h98, a0); send_byte(r, a1);
    bus_start(); send_byte(8'h99, a2); recv_byte(1'b0, d); bus_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic pulse_sample(input logic [23:0] d);
    sample_data = d; sample_stb = 1'b1; tick(1); sample_stb = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd, rd2;
    bit ok, a0, a1, a2, a3;
    tick(5); rst_n = 1'b1; tick(10);

    // R10: released line after reset; R5: mode reads zero (standby)
    check(sda_pull == 1'b0, "R10", "pull after reset", 32'(sda_pull), 0);
    read_reg(8'h07, rd, ok);
    check(ok, "R1", "address acks on read", 32'(ok), 1);
    check(rd == 8'h00, "R5", "mode reset value", rd, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) begin
        read_reg(VEC[v][23:16], rd, ok);
        check(ok, "R1", "acks during read", 32'(ok), 1);
        check(rd == VEC[v][7:0], VTAG[v], "table read", rd, VEC[v][7:0]);
      end else begin
        write_reg(VEC[v][23:16], VEC[v][15:8], ok);
        check(ok, VTAG[v], "acks during write", 32'(ok), 1);
      end
    end

    // R2: foreign address is NAKed and later bytes do nothing
    bus_start(); send_byte(8'h9A, a0); send_byte(8'h03, a1); send_byte(8'h00, a2); bus_stop();
    check(!a0, "R2", "foreign address ack", 32'(a0), 0);
    check(!a1 && !a2, "R2", "bytes after foreign address", {a1, a2}, 0);
    read_reg(8'h03, rd, ok);
    check(rd == 8'h3C, "R2", "register after foreign write", rd, 8'h3C);

    // R4: a second data byte is refused and not stored
    bus_start(); send_byte(8'h98, a0); send_byte(8'h04, a1); send_byte(8'h11, a2);
    send_byte(8'h22, a3); bus_stop();
    check(a2, "R4", "first data byte ack", 32'(a2), 1);
    check(!a3, "R4", "extra data byte ack", 32'(a3), 0);
    read_reg(8'h04, rd, ok);
    check(rd == 8'h11, "R4", "reg 4 keeps first byte", rd, 8'h11);
    read_reg(8'h05, rd, ok);
    check(rd == 8'h00, "R4", "reg 5 untouched", rd, 0);

    // R7: burst read with pointer auto-increment
    bus_start(); send_byte(8'h98, a0); send_byte(8'h03, a1);
    bus_start(); send_byte(8'h99, a2); recv_byte(1'b1, rd); recv_byte(1'b0, rd2); bus_stop();
    check(rd == 8'h3C, "R7", "burst byte 0", rd, 8'h3C);
    check(rd2 == 8'h11, "R7", "burst byte 1", rd2, 8'h11);
    check(sda_pull == 1'b0, "R10", "pull after stop", 32'(sda_pull), 0);

    // R8: idle sample strobe loads registers 0..2
    pulse_sample(24'hC3B2A1);
    bus_start(); send_byte(8'h98, a0); send_byte(8'h00, a1);
    bus_start(); send_byte(8'h99, a2); recv_byte(1'b1, rd); recv_byte(1'b1, rd2);
    check(rd == 8'hA1 && rd2 == 8'hB2, "R8", "sample bytes 0,1", {rd, rd2}, 16'hA1B2);
    recv_byte(1'b0, rd); bus_stop();
    check(rd == 8'hC3, "R8", "sample byte 2", rd, 8'hC3);

    // R9: strobe inside a transaction is dropped
    bus_start(); send_byte(8'h98, a0); send_byte(8'h00, a1);
    pulse_sample(24'h665544);
    bus_stop();
    read_reg(8'h00, rd, ok);
    check(rd == 8'hA1, "R9", "sample reg after busy strobe", rd, 8'hA1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule